// File: doc/BRIEF.md
# Burst-of-Two Quad Data Rate Static Memory

This block is a synthesizable behavioural model of a static memory with a separate read port and write port. Both ports share one address bus. Every stored location holds two words, and every access moves both words on consecutive half-cycles. Time is modelled with one fast clock and a phase flag, `k_pos`. A cycle with `k_pos` high stands for a positive input clock edge, and a cycle with `k_pos` low stands for the complementary edge. The bench and the system must drive the flag so that it alternates, starting with a positive phase after reset.

A clock pair works as follows. The positive phase may start a read (the read address is taken from the bus) and may arm a write (the first write word and its lane mask are taken). The following negative phase supplies the write address, the second write word and its lane mask, and the write is committed. So one read and one write fit into each clock pair.

Read data comes back as a two-word burst with a valid flag. A read that targets the address being written in the same pair returns the newly written contents.

Top module: `qdr_b2_sram`

## Requirements
- R1: A read starts only in a positive phase (`k_pos`=1) with `rd_sel_n`=0. `rd_sel_n` and the address bus are ignored for reads in negative phases and whenever `rd_sel_n`=1; no valid output results from them.
- R2: The first word of a read (bits W-1:0 of the location) appears on `rdata` with `rvalid`=1 exactly LAT half-cycles after its positive address phase (default LAT=2). The second word (bits 2W-1:W) follows on the very next half-cycle.
- R3: Whenever no burst word is due, `rvalid`=0 and `rdata`=0. A started burst always delivers both words, even if `rd_sel_n` is deasserted right after it starts.
- R4: A write is armed by `wr_sel_n`=0 in a positive phase, which also captures word 0 and its lane mask. In the following negative phase the bus gives the write address, and word 1 and its mask are captured there.
- R5: When `wr_sel_n`=1 in a positive phase, the data, mask and address of that pair are ignored, and no location changes. `wr_sel_n` sampled in negative phases has no effect.
- R6: `byte_wr_n[i]`=0 writes lane i (bits 9i+8:9i) of the word of that phase, and lanes with `byte_wr_n[i]`=1 keep their stored value. The two phases are masked independently.
- R7: A read whose positive phase falls in the same pair as a write to the same address returns the data as it stands after that write, lane masks included.
- R8: A read and a write to different addresses in the same pair do not disturb each other. Reads in consecutive pairs give an unbroken stream of valid words.
- R9: After reset, `rvalid`=0 and `rdata`=0, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock; each edge is one phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| k_pos | input | 1 | 1 = positive phase, 0 = negative phase |
| rd_sel_n | input | 1 | Active-low read port select |
| wr_sel_n | input | 1 | Active-low write port select |
| addr | input | AW | Shared address bus (read in positive, write in negative phase) |
| wdata | input | W | Write word for the current phase |
| byte_wr_n | input | LANES | Active-low 9-bit lane write selects |
| rdata | output | W | Read word, zero when not valid |
| rvalid | output | 1 | Read word valid |

## Verification
The assertions check on every cycle that `rvalid` is high exactly LAT and LAT+1 half-cycles after each accepted read start, and never otherwise. They also check that an idle output is zero and that a burst never shows only one valid word. What those words contain can only be shown by the bench scenarios. These are:
- full write and read-back sweeps over every address;
- a sweep over all lane masks on both phases with same-pair forwarding;
- writes with the port deselected;
- select pulses in negative phases, which must be ignored.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int LANE_W = 9;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_ARMED = 1'b1
    } wr_state_e;
endpackage

// File: rtl/qdr_array.sv
module qdr_array #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    parameter int W     = LANES * qdr_pkg::LANE_W,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [W-1:0]     wd0,
    input  logic [LANES-1:0] wm0,
    input  logic [W-1:0]     wd1,
    input  logic [LANES-1:0] wm1,
    input  logic [AW-1:0]    raddr,
    output logic [2*W-1:0]   rline
);
    localparam int LW = qdr_pkg::LANE_W;

    logic [2*W-1:0] mem [DEPTH];
    logic [2*W-1:0] old_line;
    logic [2*W-1:0] new_line;

    always_comb begin
        old_line = mem[waddr];
        new_line = old_line;
        for (int l = 0; l < LANES; l++) begin
            if (wm0[l]) new_line[l*LW +: LW]     = wd0[l*LW +: LW];
            if (wm1[l]) new_line[W + l*LW +: LW] = wd1[l*LW +: LW];
        end
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= new_line;
    end

    // same-pair write is visible to the read fetched in this cycle
    always_comb begin
        if (we && (waddr == raddr)) rline = new_line;
        else                        rline = mem[raddr];
    end
endmodule

// File: rtl/qdr_burst_out.sv
module qdr_burst_out #(
    parameter int W   = 36,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [2*W-1:0] line,
    output logic [W-1:0]   rdata,
    output logic           rvalid
);
    localparam int DLY = (LAT > 2) ? LAT - 2 : 0;

    logic           ld_eff;
    logic [2*W-1:0] line_eff;

    generate
        if (DLY == 0) begin : g_direct
            assign ld_eff   = load;
            assign line_eff = line;
        end else begin : g_delay
            logic [DLY-1:0] v_q;
            logic [2*W-1:0] l_q [DLY];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q <= '0;
                    for (int i = 0; i < DLY; i++) l_q[i] <= '0;
                end else begin
                    v_q[0] <= load;
                    l_q[0] <= line;
                    for (int i = 1; i < DLY; i++) begin
                        v_q[i] <= v_q[i-1];
                        l_q[i] <= l_q[i-1];
                    end
                end
            end
            assign ld_eff   = v_q[DLY-1];
            assign line_eff = l_q[DLY-1];
        end
    endgenerate

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
        logic         pend;
        logic [W-1:0] hold;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_eff) begin
            s_d.valid = 1'b1;
            s_d.data  = line_eff[W-1:0];
            s_d.hold  = line_eff[2*W-1:W];
            s_d.pend  = 1'b1;
        end else if (s_q.pend) begin
            s_d.valid = 1'b1;
            s_d.data  = s_q.hold;
            s_d.pend  = 1'b0;
        end else begin
            s_d.valid = 1'b0;
            s_d.data  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata  = s_q.data;
    assign rvalid = s_q.valid;
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    parameter int LAT   = 2,
    localparam int W    = LANES * qdr_pkg::LANE_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             k_pos,
    input  logic             rd_sel_n,
    input  logic             wr_sel_n,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wdata,
    input  logic [LANES-1:0] byte_wr_n,
    output logic [W-1:0]     rdata,
    output logic             rvalid
);
    import qdr_pkg::*;

    typedef struct packed {
        wr_state_e        wr_st;
        logic [W-1:0]     wd0;
        logic [LANES-1:0] wm0;
        logic             rd_pend;
        logic [AW-1:0]    raddr;
    } ctl_t;

    ctl_t c_d, c_q;
    logic commit;

    always_comb begin
        c_d         = c_q;
        c_d.rd_pend = 1'b0;
        commit      = 1'b0;
        if (k_pos) begin
            c_d.rd_pend = !rd_sel_n;
            if (!rd_sel_n) c_d.raddr = addr;
            if (!wr_sel_n) begin
                c_d.wr_st = WR_ARMED;
                c_d.wd0   = wdata;
                c_d.wm0   = ~byte_wr_n;
            end else begin
                c_d.wr_st = WR_IDLE;
            end
        end else begin
            commit    = (c_q.wr_st == WR_ARMED);
            c_d.wr_st = WR_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    logic [2*W-1:0] rline;

    qdr_array #(
        .DEPTH (DEPTH),
        .LANES (LANES),
        .W     (W),
        .AW    (AW)
    ) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (addr),
        .wd0   (c_q.wd0),
        .wm0   (c_q.wm0),
        .wd1   (wdata),
        .wm1   (~byte_wr_n),
        .raddr (c_q.raddr),
        .rline (rline)
    );

    qdr_burst_out #(
        .W   (W),
        .LAT (LAT)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (c_q.rd_pend),
        .line   (rline),
        .rdata  (rdata),
        .rvalid (rvalid)
    );
endmodule

// File: rtl/qdr_b2_sram_chk.sv
module qdr_b2_sram_chk #(
    parameter int W   = 36,
    parameter int LAT = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         k_pos,
    input logic         rd_sel_n,
    input logic [W-1:0] rdata,
    input logic         rvalid
);
    logic [LAT:0] started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) started <= '0;
        else        started <= {started[LAT-1:0], k_pos && !rd_sel_n};
    end

    p_first_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        started[LAT-1] |-> rvalid);

    p_second_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        started[LAT] |-> rvalid);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (started[LAT-1] || started[LAT]));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    p_burst_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |=> rvalid);
endmodule

bind qdr_b2_sram qdr_b2_sram_chk #(.W(W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .k_pos    (k_pos),
    .rd_sel_n (rd_sel_n),
    .rdata    (rdata),
    .rvalid   (rvalid)
);

// File: tb/test_qdr_b2_sram.sv
module test_qdr_b2_sram;
    localparam int DEPTH = 16;
    localparam int LANES = 4;
    localparam int W     = 36;
    localparam int AW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             k_pos = 1'b0;
    logic             rd_sel_n = 1'b1;
    logic             wr_sel_n = 1'b1;
    logic [AW-1:0]    addr = '0;
    logic [W-1:0]     wdata = '0;
    logic [LANES-1:0] byte_wr_n = '1;
    logic [W-1:0]     rdata;
    logic             rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0] model [DEPTH][2];
    logic         exp_v;
    logic [W-1:0] exp_w0, exp_w1;
    string        exp_tag;

    always #10 clk = ~clk;

    qdr_b2_sram i_qdr_b2_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .k_pos     (k_pos),
        .rd_sel_n  (rd_sel_n),
        .wr_sel_n  (wr_sel_n),
        .addr      (addr),
        .wdata     (wdata),
        .byte_wr_n (byte_wr_n),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    function automatic logic [W-1:0] pat(int a, int w, int s);
        logic [63:0] x;
        x = (64'(a) * 64'h9E3779B97F4A7C15) ^ (64'(w + 3) * 64'hC2B2AE3D27D4EB4F)
            ^ (64'(s) * 64'h165667B19E3779F9);
        return x[W-1:0] ^ x[63:64-W];
    endfunction

    task automatic check(string tag, logic ev, logic [W-1:0] ed);
        n_cmp++;
        if (rvalid !== ev || rdata !== (ev ? ed : '0)) begin
            n_bad++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ev ? ed : '0);
        end
    endtask

    // one clock pair: positive phase then negative phase
    task automatic pair(bit rd, int ra, bit wr, int wa,
                        logic [W-1:0] d0, logic [LANES-1:0] m0n,
                        logic [W-1:0] d1, logic [LANES-1:0] m1n, string tag);
        @(negedge clk);
        check(exp_tag, exp_v, exp_w0);
        k_pos     = 1'b1;
        rd_sel_n  = !rd;
        wr_sel_n  = !wr;
        addr      = AW'(rd ? ra : wa + 5);
        wdata     = d0;
        byte_wr_n = m0n;
        @(negedge clk);
        check(exp_tag, exp_v, exp_w1);
        k_pos     = 1'b0;
        rd_sel_n  = 1'b0;       // R1: ignored in negative phase
        wr_sel_n  = 1'b0;       // R5: ignored in negative phase
        addr      = AW'(wa);
        wdata     = d1;
        byte_wr_n = m1n;
        if (wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (!m0n[l]) model[wa][0][l*9 +: 9] = d0[l*9 +: 9];
                if (!m1n[l]) model[wa][1][l*9 +: 9] = d1[l*9 +: 9];
            end
        end
        exp_v   = rd;
        exp_w0  = rd ? model[ra][0] : '0;
        exp_w1  = rd ? model[ra][1] : '0;
        exp_tag = rd ? tag : "R3";
    endtask

    task automatic idle_pair(string tag);
        pair(1'b0, 0, 1'b0, 0, '0, '1, '0, '1, tag);
    endtask

    initial begin
        exp_v = 1'b0; exp_w0 = '0; exp_w1 = '0; exp_tag = "R3";
        for (int a = 0; a < DEPTH; a++) begin
            model[a][0] = '0;
            model[a][1] = '0;
        end
        repeat (3) @(negedge clk);
        check("R9", 1'b0, '0);
        rst_n = 1'b1;
        check("R9", 1'b0, '0);

        // R4: fill every address, full masks
        for (int a = 0; a < DEPTH; a++)
            pair(1'b0, 0, 1'b1, a, pat(a, 0, 1), '0, pat(a, 1, 1), '0, "R4");

        // R8: read each address while writing a different one
        for (int a = 0; a < DEPTH; a++)
            pair(1'b1, a, 1'b1, (a + 8) % DEPTH, pat(a, 0, 2), '0, pat(a, 1, 2), '0, "R8");
        idle_pair("R3");

        // R6/R7: every lane mask on both phases, read in the same pair
        for (int m = 0; m < 16; m++) begin
            pair(1'b1, 3, 1'b1, 3, pat(m, 0, 10), LANES'(m), pat(m, 1, 10),
                 LANES'(~m), "R7");
            pair(1'b1, 3, 1'b0, 0, '0, '1, '0, '1, "R6");
        end
        idle_pair("R3");

        // R5: deselected write with live data and address
        pair(1'b0, 0, 1'b0, 5, pat(99, 0, 5), '0, pat(99, 1, 5), '0, "R5");
        pair(1'b1, 5, 1'b0, 0, '0, '1, '0, '1, "R5");
        // R5: a positive phase with byte selects all high writes nothing
        pair(1'b0, 0, 1'b1, 6, pat(7, 0, 6), '1, pat(7, 1, 6), '1, "R5");
        pair(1'b1, 6, 1'b0, 0, '0, '1, '0, '1, "R5");

        // R1: reads deselected over several pairs give no output
        for (int a = 0; a < 4; a++) idle_pair("R1");

        // R2/R3: isolated read then stop; burst completes
        pair(1'b1, 9, 1'b0, 0, '0, '1, '0, '1, "R2");
        idle_pair("R3");
        idle_pair("R3");
        pair(1'b1, 15, 1'b0, 0, '0, '1, '0, '1, "R2");
        pair(1'b1, 0, 1'b0, 0, '0, '1, '0, '1, "R8");
        idle_pair("R3");
        idle_pair("R3");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule